// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block holds the programmed start address and transfer count for a set of DMA channels, and returns the live transfer position to software. A byte-wide port space of eight locations reaches the registers. The upper port bits choose the channel and the lowest bit chooses between the address register and the count register. Each 16-bit register is reached as two byte accesses in a row. A single byte-order pointer, shared by all channels, decides which half each access touches. Every channel access flips this pointer. A neighbouring control block can force the pointer back to the low byte.

A write to the high byte restarts the channel. The working start address is reloaded from the programmed address, scaled by a width shift, and the progress count is cleared. The transfer engine reports progress for each channel through a strobe and a shared value. A read of the address port returns the start address moved by the progress, upward or downward according to a per-channel direction input. A read of the count port returns the scaled count minus the progress. Each channel also drives its start address and its total transfer length to the engine. A shift of 0 gives byte units, and a shift of 1 suits a controller that moves 16-bit words.

Top module: `dma_chan_regs`

## Requirements
- R1: Port bits [2:1] select the channel and port bit 0 selects the register: 0 is the address, 1 is the count. An access to one channel leaves every other channel's readback unchanged.
- R2: Each cycle with `rd_en` or `wr_en` high toggles the shared byte pointer. Pointer 0 reaches bits 7:0 and pointer 1 reaches bits 15:8. With no access and no clear, the pointer holds.
- R3: `ptr_clear` forces the pointer to 0 at the next edge, and it wins over a toggle in the same cycle. An access in that cycle still uses the pointer value it had before the edge.
- R4: A write with pointer 0 changes only bits 7:0 of the selected base register. It does not restart the channel: the start address and the progress are kept.
- R5: A write with pointer 1 sets bits 15:8 of the selected base register and restarts the channel. The start address becomes the base address shifted left by WSHIFT, and the progress becomes 0. This restart wins over a progress strobe to the same channel in the same cycle.
- R6: An address read returns the start address plus the progress. When `dir_down` for that channel is 1, it returns the start address minus the progress.
- R7: A count read returns (base count << WSHIFT) minus the progress.
- R8: The read byte is (value >> (WSHIFT + 8·pointer)) & 0xFF. It appears on `rd_data` at the edge that takes `rd_en`, and `rd_data` holds when there is no read.
- R9: `chan_len` for each channel equals (base count + 1) << WSHIFT.
- R10: `prog_we[c]` loads `prog_val` as the progress of channel c only.
- R11: After a synchronous reset, every base register, start address, progress value, the pointer and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_sel | input | 3 | Port index: channel in [2:1], register kind in [0] |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, registered |
| ptr_clear | input | 1 | Force byte pointer to low byte |
| dir_down | input | 4 | Per-channel decrement direction |
| prog_we | input | 4 | Per-channel progress load strobe |
| prog_val | input | 17 | Progress value in units of the shifted address |
| chan_start | output | 64 | Start address per channel, 16+WSHIFT bits each, channel 0 lowest |
| chan_len | output | 68 | Transfer length per channel, 17+WSHIFT bits each, channel 0 lowest |

## Verification
The bench builds the block with WSHIFT = 1, which makes `prog_val` 18 bits wide, the start slices 17 bits and the length slices 18 bits. With this setting every readback has to drop the extra low bit before it picks a byte. A scaling error or an off-by-one in the byte shift therefore shows up directly in the read bytes. One channel runs in the decrement direction with a progress that borrows across the byte boundary. Other checks reach the case where the pointer clear and a read fall in the same cycle, and the case where a restart and a progress strobe fall in the same cycle.

// File: rtl/dma_regs_pkg.sv
// Shared constants for the DMA channel register file.
// Assumes byte-wide port accesses and 16-bit programmed registers.
package dma_regs_pkg;
    localparam int REG_BITS  = 16;
    localparam int BYTE_BITS = 8;
    localparam logic KIND_ADDR  = 1'b0;
    localparam logic KIND_COUNT = 1'b1;
endpackage

// File: rtl/dma_byte_ptr.sv
// Shared low/high byte pointer.
// Toggles on every channel access; a clear forces low byte and wins.
module dma_byte_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic access,
    output logic ptr
);
    // Pointer state update with clear priority
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr <= 1'b0;
        else if (clr)     ptr <= 1'b0;
        else if (access)  ptr <= ~ptr;
    end
endmodule

// File: rtl/dma_chan_slot.sv
// One channel: base address/count, working start address and progress.
// Assumes wr_hit is already qualified for this channel.
module dma_chan_slot
    import dma_regs_pkg::*;
#(
    parameter int WSHIFT = 0,
    localparam int AW = REG_BITS + WSHIFT,
    localparam int PW = REG_BITS + 1 + WSHIFT,
    localparam int VW = REG_BITS + 2 + WSHIFT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_hit,
    input  logic                 kind,
    input  logic                 ptr,
    input  logic [BYTE_BITS-1:0] wr_data,
    input  logic                 prog_we,
    input  logic [PW-1:0]        prog_val,
    input  logic                 dir_down,
    output logic [VW-1:0]        addr_view,
    output logic [VW-1:0]        cnt_view,
    output logic [AW-1:0]        start_addr,
    output logic [PW-1:0]        xfer_len
);
    logic [REG_BITS-1:0] base_addr;
    logic [REG_BITS-1:0] base_cnt;
    logic [PW-1:0]       prog;
    logic                restart;
    logic [REG_BITS-1:0] next_base_addr;

    assign restart        = wr_hit && ptr;
    assign next_base_addr = (kind == KIND_ADDR) ? {wr_data, base_addr[7:0]} : base_addr;

    // Programmed base registers, byte-at-a-time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
        end else if (wr_hit) begin
            if (kind == KIND_ADDR) begin
                if (ptr) base_addr[15:8] <= wr_data;
                else     base_addr[7:0]  <= wr_data;
            end else begin
                if (ptr) base_cnt[15:8]  <= wr_data;
                else     base_cnt[7:0]   <= wr_data;
            end
        end
    end

    // Working start address, reloaded on channel restart
    always_ff @(posedge clk) begin
        if (!rst_n)       start_addr <= '0;
        else if (restart) start_addr <= AW'(next_base_addr) << WSHIFT;
    end

    // Progress from the transfer engine; restart has priority
    always_ff @(posedge clk) begin
        if (!rst_n)       prog <= '0;
        else if (restart) prog <= '0;
        else if (prog_we) prog <= prog_val;
    end

    // Live readback values and transfer length
    always_comb begin
        addr_view = dir_down ? (VW'(start_addr) - VW'(prog)) : (VW'(start_addr) + VW'(prog));
        cnt_view  = (VW'(base_cnt) << WSHIFT) - VW'(prog);
        xfer_len  = (PW'(base_cnt) + PW'(1)) << WSHIFT;
    end
endmodule

// File: rtl/dma_read_mux.sv
// Selects a channel's view, extracts one byte and registers it.
// Assumes views are packed channel 0 lowest.
module dma_read_mux
    import dma_regs_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int WSHIFT = 0,
    localparam int CH_W = $clog2(NUM_CH),
    localparam int VW = REG_BITS + 2 + WSHIFT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_en,
    input  logic [CH_W-1:0]        ch,
    input  logic                   kind,
    input  logic                   ptr,
    input  logic [NUM_CH*VW-1:0]   addr_views,
    input  logic [NUM_CH*VW-1:0]   cnt_views,
    output logic [BYTE_BITS-1:0]   rd_data
);
    logic [VW-1:0]        view;
    logic [BYTE_BITS-1:0] pick;

    // Byte extraction from the selected view
    always_comb begin
        view = (kind == KIND_COUNT) ? cnt_views[int'(ch)*VW +: VW] : addr_views[int'(ch)*VW +: VW];
        pick = BYTE_BITS'(view >> (WSHIFT + (ptr ? BYTE_BITS : 0)));
    end

    // Read data register, updated only on a read
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= pick;
    end
endmodule

// File: rtl/dma_chan_regs.sv
// Top of the DMA channel address/count register file.
// Assumes rd_en and wr_en are not both high; both still toggle the pointer once.
module dma_chan_regs
    import dma_regs_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int WSHIFT = 0,
    localparam int CH_W = $clog2(NUM_CH),
    localparam int AW = REG_BITS + WSHIFT,
    localparam int PW = REG_BITS + 1 + WSHIFT,
    localparam int VW = REG_BITS + 2 + WSHIFT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CH_W:0]         port_sel,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [BYTE_BITS-1:0]  wr_data,
    output logic [BYTE_BITS-1:0]  rd_data,
    input  logic                  ptr_clear,
    input  logic [NUM_CH-1:0]     dir_down,
    input  logic [NUM_CH-1:0]     prog_we,
    input  logic [PW-1:0]         prog_val,
    output logic [NUM_CH*AW-1:0]  chan_start,
    output logic [NUM_CH*PW-1:0]  chan_len
);
    logic [CH_W-1:0]      ch;
    logic                 kind;
    logic                 byte_ptr;
    logic [NUM_CH*VW-1:0] addr_views;
    logic [NUM_CH*VW-1:0] cnt_views;

    assign ch   = port_sel[CH_W:1];
    assign kind = port_sel[0];

    dma_byte_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ptr_clear),
        .access (rd_en || wr_en),
        .ptr    (byte_ptr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dma_chan_slot #(.WSHIFT(WSHIFT)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_hit     (wr_en && (ch == CH_W'(c))),
            .kind       (kind),
            .ptr        (byte_ptr),
            .wr_data    (wr_data),
            .prog_we    (prog_we[c]),
            .prog_val   (prog_val),
            .dir_down   (dir_down[c]),
            .addr_view  (addr_views[c*VW +: VW]),
            .cnt_view   (cnt_views[c*VW +: VW]),
            .start_addr (chan_start[c*AW +: AW]),
            .xfer_len   (chan_len[c*PW +: PW])
        );
    end

    dma_read_mux #(.NUM_CH(NUM_CH), .WSHIFT(WSHIFT)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .ch         (ch),
        .kind       (kind),
        .ptr        (byte_ptr),
        .addr_views (addr_views),
        .cnt_views  (cnt_views),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/dma_chan_regs_chk.sv
// Temporal checks on the register file, bound to the top module.
module dma_chan_regs_chk #(
    parameter int NUM_CH = 4,
    parameter int WSHIFT = 0,
    localparam int CH_W = $clog2(NUM_CH),
    localparam int AW = 16 + WSHIFT
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [CH_W:0]        port_sel,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [7:0]           wr_data,
    input logic [7:0]           rd_data,
    input logic                 ptr_clear,
    input logic                 byte_ptr,
    input logic [NUM_CH*AW-1:0] chan_start
);
    logic [CH_W-1:0] last_ch;
    logic [7:0]      last_hi;

    // Remember the channel addressed in the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) last_ch <= '0;
        else        last_ch <= port_sel[CH_W:1];
    end

    // High byte of the start address of that channel
    always_comb last_hi = chan_start[int'(last_ch)*AW + WSHIFT + 8 +: 8];

    assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clear |=> (byte_ptr == 1'b0));

    assert_ptr_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && !ptr_clear) |=> (byte_ptr != $past(byte_ptr)));

    assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wr_en && !ptr_clear) |=> $stable(byte_ptr));

    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    assert_restart_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && byte_ptr && !port_sel[0]) |=> (last_hi == $past(wr_data)));

    assert_low_write_keeps_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !byte_ptr) |=> $stable(chan_start));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NUM_CH(NUM_CH), .WSHIFT(WSHIFT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_sel   (port_sel),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .ptr_clear  (ptr_clear),
    .byte_ptr   (byte_ptr),
    .chan_start (chan_start)
);

// File: tb/sim_dma_chan_regs.sv
`timescale 1ns/1ps
module sim_dma_chan_regs;
    localparam int NUM_CH = 4;
    localparam int WS = 1;
    localparam int AW = 16 + WS;
    localparam int PW = 17 + WS;

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PG = 2'd2, OP_CL = 2'd3;
    localparam int NV = 42;
    // {op, port, data}: WR data byte, RD expected byte, PG progress value
    localparam logic [22:0] VEC [NV] = '{
        {OP_WR,3'd0,18'h34}, {OP_WR,3'd0,18'h12},             // R5 ch0 addr 0x1234
        {OP_RD,3'd0,18'h34}, {OP_RD,3'd0,18'h12},             // R2 R8
        {OP_WR,3'd1,18'hFF}, {OP_WR,3'd1,18'h00},             // ch0 count 0x00FF
        {OP_RD,3'd1,18'hFF}, {OP_RD,3'd1,18'h00},             // R7
        {OP_PG,3'd0,18'h10},                                  // R10
        {OP_RD,3'd0,18'h3C}, {OP_RD,3'd0,18'h12},             // R6 up
        {OP_RD,3'd1,18'hF7}, {OP_RD,3'd1,18'h00},             // R7
        {OP_WR,3'd4,18'h00}, {OP_WR,3'd4,18'h01},             // ch2 addr 0x0100
        {OP_WR,3'd5,18'h03}, {OP_WR,3'd5,18'h00},             // ch2 count 3
        {OP_PG,3'd4,18'h04},
        {OP_RD,3'd4,18'hFE}, {OP_RD,3'd4,18'h00},             // R6 down, borrow
        {OP_RD,3'd5,18'h01}, {OP_RD,3'd5,18'h00},             // R7
        {OP_WR,3'd6,18'hAA}, {OP_CL,3'd0,18'h0},              // R3
        {OP_WR,3'd6,18'hBB}, {OP_WR,3'd6,18'hCC},
        {OP_RD,3'd6,18'hBB}, {OP_RD,3'd6,18'hCC},             // R3 R1
        {OP_WR,3'd0,18'h00}, {OP_CL,3'd0,18'h0},              // R4 low write
        {OP_RD,3'd0,18'h3C}, {OP_RD,3'd0,18'h12},             // R4 no restart
        {OP_WR,3'd0,18'h00}, {OP_WR,3'd0,18'h12},             // R5 restart
        {OP_RD,3'd0,18'h00}, {OP_RD,3'd0,18'h12},
        {OP_WR,3'd5,18'h03}, {OP_WR,3'd5,18'h00},             // R5 count restart
        {OP_RD,3'd4,18'h00}, {OP_RD,3'd4,18'h01},
        {OP_RD,3'd2,18'h00}, {OP_RD,3'd2,18'h00}              // R1 ch1 untouched
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] port_sel = '0;
    logic wr_en = 1'b0, rd_en = 1'b0, ptr_clear = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [NUM_CH-1:0] dir_down = 4'b0100;
    logic [NUM_CH-1:0] prog_we = '0;
    logic [PW-1:0] prog_val = '0;
    logic [NUM_CH*AW-1:0] chan_start;
    logic [NUM_CH*PW-1:0] chan_len;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dma_chan_regs #(.NUM_CH(NUM_CH), .WSHIFT(WS)) u0 (
        .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .ptr_clear(ptr_clear), .dir_down(dir_down),
        .prog_we(prog_we), .prog_val(prog_val), .chan_start(chan_start), .chan_len(chan_len)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; ptr_clear = 0; prog_we = '0;
    endtask

    task automatic apply(input logic [22:0] v);
        @(negedge clk);
        port_sel = v[20:18];
        case (v[22:21])
            OP_WR: begin wr_en = 1; wr_data = v[7:0]; end
            OP_RD: rd_en = 1;
            OP_PG: begin prog_we[v[20:19]] = 1'b1; prog_val = v[PW-1:0]; end
            default: ptr_clear = 1;
        endcase
        @(negedge clk);
        idle();
        if (v[22:21] == OP_RD) check("R1/R6/R7/R8 vector read", 32'(rd_data), 32'(v[7:0]));
    endtask

    task automatic rd_byte(input logic [2:0] p, input logic clr, input string req, input logic [7:0] exp);
        @(negedge clk);
        port_sel = p; rd_en = 1; ptr_clear = clr;
        @(negedge clk);
        idle();
        check(req, 32'(rd_data), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state seen at the ports
        check("R11 rd_data", 32'(rd_data), 32'h0);
        check("R11 start ch0", 32'(chan_start[0 +: AW]), 32'h0);
        check("R9 R11 len ch0 after reset", 32'(chan_len[0 +: PW]), 32'h2);

        for (int i = 0; i < NV; i++) apply(VEC[i]);

        // R9: lengths from programmed counts
        check("R9 len ch0", 32'(chan_len[0 +: PW]), 32'h200);
        check("R9 len ch2", 32'(chan_len[2*PW +: PW]), 32'h8);
        check("R5 start ch0", 32'(chan_start[0 +: AW]), 32'h2400);
        check("R5 start ch3", 32'(chan_start[3*AW +: AW]), 32'h19976);

        // R3: clear in the same cycle as a read; the read uses low byte, then pointer stays 0
        rd_byte(3'd0, 1'b1, "R3 read with clear", 8'h00);
        rd_byte(3'd0, 1'b0, "R3 clear beats toggle", 8'h00);

        // R5: restart wins over same-cycle progress strobe on ch0 (pointer now 1)
        @(negedge clk);
        port_sel = 3'd0; wr_en = 1; wr_data = 8'h12; prog_we = 4'b0001; prog_val = PW'(18'h40);
        @(negedge clk);
        idle();
        rd_byte(3'd0, 1'b0, "R5 restart beats progress", 8'h00);
        rd_byte(3'd0, 1'b0, "R5 restart beats progress hi", 8'h12);

        // R10: progress strobe on ch3 only; ch0 unaffected
        @(negedge clk);
        prog_we = 4'b1000; prog_val = PW'(18'h2);
        @(negedge clk);
        idle();
        rd_byte(3'd6, 1'b0, "R10 ch3 progress", 8'hBC);
        rd_byte(3'd0, 1'b1, "R10 ch0 untouched", 8'h12);

        // R11: reset in mid-state clears everything
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        check("R11 rd_data after reset", 32'(rd_data), 32'h0);
        check("R11 start ch3 after reset", 32'(chan_start[3*AW +: AW]), 32'h0);
        rd_byte(3'd0, 1'b0, "R11 ch0 addr after reset", 8'h00);
        rd_byte(3'd1, 1'b0, "R11 pointer low after reset", 8'h00);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule